// File: doc/BRIEF.md
# Floating-point compare flag unit

This unit takes a pair of IEEE-754 single-precision operands on a valid/ready handshake and sorts them into one of four outcomes: greater, less, equal or unordered. It reports the outcome as three condition flags (zero, parity, carry), held in a register. It also drives overflow, sign and auxiliary flags that always read zero. A scalar compare pipeline feeds it one pair at a time and reads the flags back once the done pulse arrives.

A mode input selects the compare behaviour. Quiet compares treat only signaling NaNs as invalid. Signaling compares treat every NaN as invalid. The unit also detects denormal operands. A denormals-as-zero input can fold them to signed zero, which also removes the denormal condition. Each condition has a mask input and a sticky status bit. A condition that is detected and not masked leaves the flag register as it was, and the unit raises an exception pulse alongside done.

Top module: `fcmp_flag_unit`

## Requirements
- R1: After reset, done, exception, the zero/parity/carry flags and both sticky bits are 0. in_ready rises on the first clock edge after reset is released.
- R2: When a result is applied, the flags {zf,pf,cf} read 000 for greater (a > b), 001 for less, 100 for equal and 111 for unordered. Done is high in the cycle after a pair is accepted.
- R3: An operand with exponent 8'hFF and a nonzero fraction is a NaN. Any NaN operand gives unordered. Such a NaN is signaling when fraction bit 22 is 0 and quiet when that bit is 1.
- R4: Positive and negative zero compare equal. Otherwise the ordering follows sign and magnitude, with the infinities at the extremes.
- R5: flag_of, flag_sf and flag_af are 0 at all times.
- R6: With sig_mode=0, the invalid condition is raised only for a signaling NaN operand. With sig_mode=1, it is raised for any NaN operand.
- R7: If the invalid condition is raised with mask_inv=0, or the denormal condition is raised with mask_den=0, the flags keep their previous value. out_exc is then high together with out_done.
- R8: The denormal condition is raised when either operand has exponent 0 and a nonzero fraction, neither operand is a NaN, and daz_en=0.
- R9: With daz_en=1, a denormal operand compares as a zero of its own sign, and no denormal condition is raised.
- R10: A detected condition sets its sticky bit whether it is masked or not. A sticky bit clears only on a cycle with sticky_clr=1. A set in the same cycle as a clear takes priority.
- R11: out_done pulses for exactly one cycle per accepted pair and never without an accepted pair. The flags change only in a cycle where out_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Unit accepts a pair this cycle |
| opa | input | 32 | First operand, single precision |
| opb | input | 32 | Second operand, single precision |
| sig_mode | input | 1 | 1: every NaN is invalid; 0: only signaling NaN |
| daz_en | input | 1 | Treat denormal operands as signed zero |
| mask_inv | input | 1 | Mask for the invalid condition |
| mask_den | input | 1 | Mask for the denormal condition |
| sticky_clr | input | 1 | Clear both sticky status bits |
| out_done | output | 1 | One-cycle pulse per completed compare |
| out_exc | output | 1 | Unmasked condition blocked the flag update |
| flag_zf | output | 1 | Zero flag |
| flag_pf | output | 1 | Parity flag |
| flag_cf | output | 1 | Carry flag |
| flag_of | output | 1 | Overflow flag, always 0 |
| flag_sf | output | 1 | Sign flag, always 0 |
| flag_af | output | 1 | Auxiliary flag, always 0 |
| stat_inv | output | 1 | Sticky invalid status |
| stat_den | output | 1 | Sticky denormal status |

## Verification
The hardest case to see from the ports is a blocked update. It is visible only if the held flags differ from the code the blocked compare would have produced. The vector table therefore places each unmasked-exception vector after an ordered compare whose code differs, and expects the earlier code to survive. Two other interactions are hard to reach. One is a denormal operand paired with a NaN, where the denormal condition must stay silent. The other is a sticky clear that lands in the same cycle as a new detection. Directed steps after the table set up both.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MAG_W   = FP_W - 1;
  localparam int FLAG_W  = 3;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic             is_den;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } fp_class_t;

  // Split a value into its class bits; daz folds denormals to signed zero
  function automatic fp_class_t fp_classify(input logic [FP_W-1:0] v, input logic daz);
    fp_class_t c;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              raw_den;
    ex = v[FP_W-2:FRAC_W];
    fr = v[FRAC_W-1:0];
    raw_den   = (ex == '0) && (fr != '0);
    c.is_nan  = (&ex) && (fr != '0);
    c.is_snan = c.is_nan && !fr[FRAC_W-1];
    c.is_den  = raw_den && !daz;
    c.is_zero = (ex == '0) && ((fr == '0) || daz);
    c.sign    = v[FP_W-1];
    c.mag     = c.is_zero ? '0 : v[MAG_W-1:0];
    return c;
  endfunction

  // Monotonic unsigned key for ordered (non-NaN, non-double-zero) values
  function automatic logic [FP_W-1:0] order_key(input fp_class_t c);
    return c.sign ? {1'b0, ~c.mag} : {1'b1, c.mag};
  endfunction

  // Outcome to {zf, pf, cf}
  function automatic logic [FLAG_W-1:0] flag_code(input cmp_res_e r);
    logic [FLAG_W-1:0] f;
    unique case (r)
      CMP_GT:  f = 3'b000;
      CMP_LT:  f = 3'b001;
      CMP_EQ:  f = 3'b100;
      default: f = 3'b111;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [FP_W-1:0] val,
  input  logic            daz,
  output fp_class_t       cls
);

  assign cls = fp_classify(val, daz);

  always_comb begin
    assert (!(cls.is_nan && cls.is_zero)) else $error("p_nan_not_zero_r3");
    assert (!(cls.is_den && cls.is_nan)) else $error("p_den_not_nan_r8");
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  output cmp_res_e  res
);

  logic            nan_any;
  logic            both_zero;
  logic [FP_W-1:0] key_a;
  logic [FP_W-1:0] key_b;

  assign nan_any   = cls_a.is_nan | cls_b.is_nan;
  assign both_zero = cls_a.is_zero & cls_b.is_zero;
  assign key_a     = order_key(cls_a);
  assign key_b     = order_key(cls_b);

  always_comb begin
    if (nan_any)            res = CMP_UN;
    else if (both_zero)     res = CMP_EQ;
    else if (key_a > key_b) res = CMP_GT;
    else if (key_a < key_b) res = CMP_LT;
    else                    res = CMP_EQ;
  end

  // R4: signed zeros never come out ordered against each other
  always_comb begin
    if (both_zero) assert (res == CMP_EQ) else $error("p_zero_equal_r4");
  end

endmodule

// File: rtl/fcmp_except.sv
module fcmp_except
  import fcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      sig_mode,
  input  logic      mask_inv,
  input  logic      mask_den,
  input  logic      sticky_clr,
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  output logic      inv_det,
  output logic      den_det,
  output logic      blocked,
  output logic      stat_inv,
  output logic      stat_den
);

  logic nan_any;
  logic snan_any;

  assign nan_any  = cls_a.is_nan | cls_b.is_nan;
  assign snan_any = cls_a.is_snan | cls_b.is_snan;
  assign inv_det  = sig_mode ? nan_any : snan_any;
  assign den_det  = !nan_any && (cls_a.is_den | cls_b.is_den);
  assign blocked  = (inv_det & ~mask_inv) | (den_det & ~mask_den);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_inv <= 1'b0;
      stat_den <= 1'b0;
    end else begin
      stat_inv <= (stat_inv & ~sticky_clr) | (fire & inv_det);
      stat_den <= (stat_den & ~sticky_clr) | (fire & den_det);
    end
  end

  p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (inv_det || den_det) |=> (stat_inv || stat_den));
  p_sticky_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr && !fire |=> $stable({stat_inv, stat_den}));
  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr && !fire |=> !stat_inv && !stat_den);

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FP_W-1:0] opa,
  input  logic [FP_W-1:0] opb,
  input  logic            sig_mode,
  input  logic            daz_en,
  input  logic            mask_inv,
  input  logic            mask_den,
  input  logic            sticky_clr,
  output logic            out_done,
  output logic            out_exc,
  output logic            flag_zf,
  output logic            flag_pf,
  output logic            flag_cf,
  output logic            flag_of,
  output logic            flag_sf,
  output logic            flag_af,
  output logic            stat_inv,
  output logic            stat_den
);

  logic [FP_W-1:0]   ops [NUM_OPS];
  fp_class_t         cls [NUM_OPS];
  cmp_res_e          cmp_res;
  logic              accept;
  logic              inv_det;
  logic              den_det;
  logic              blocked;
  logic              ready_q;
  logic              done_q;
  logic              exc_q;
  logic [FLAG_W-1:0] flags_q;

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fcmp_classify u_cls (
      .val (ops[g]),
      .daz (daz_en),
      .cls (cls[g])
    );
  end

  fcmp_order u_order (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .res   (cmp_res)
  );

  fcmp_except u_except (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (accept),
    .sig_mode   (sig_mode),
    .mask_inv   (mask_inv),
    .mask_den   (mask_den),
    .sticky_clr (sticky_clr),
    .cls_a      (cls[0]),
    .cls_b      (cls[1]),
    .inv_det    (inv_det),
    .den_det    (den_det),
    .blocked    (blocked),
    .stat_inv   (stat_inv),
    .stat_den   (stat_den)
  );

  assign accept = in_valid & ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= accept;
      exc_q   <= accept & blocked;
      if (accept && !blocked) flags_q <= flag_code(cmp_res);
    end
  end

  assign in_ready = ready_q;
  assign out_done = done_q;
  assign out_exc  = exc_q;
  assign {flag_zf, flag_pf, flag_cf} = flags_q;
  // Overflow, sign and auxiliary flags carry no compare information
  assign flag_of = 1'b0;
  assign flag_sf = 1'b0;
  assign flag_af = 1'b0;

  p_done_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_done);
  p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_done);
  p_flags_need_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> $stable(flags_q));
  p_exc_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> out_done);
  p_exc_holds_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> $stable(flags_q));
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q inside {3'b000, 3'b001, 3'b100, 3'b111});
  p_unordered_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls[0].is_nan || cls[1].is_nan) && !blocked |=> flags_q == 3'b111);
  p_daz_no_den_r9: assert property (@(posedge clk) disable iff (!rst_n)
    daz_en |-> !den_det);
  p_quiet_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_mode && inv_det |-> (cls[0].is_snan || cls[1].is_snan));

endmodule

// File: tb/test_fcmp_flag_unit.sv
module test_fcmp_flag_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 25;
  // {opa, opb, {sig,daz,mask_inv,mask_den}, code {zf,pf,cf}, {exc,inv,den}}
  localparam logic [73:0] VECS [0:NV-1] = '{
    {32'h40000000, 32'h3F800000, 4'b0011, 3'b000, 3'b000}, // R2 greater
    {32'h3F800000, 32'h40000000, 4'b0011, 3'b001, 3'b000}, // R2 less
    {32'hBF800000, 32'h3F800000, 4'b0011, 3'b001, 3'b000}, // R4 sign
    {32'hBF800000, 32'hBF800000, 4'b0011, 3'b100, 3'b000}, // R2 equal
    {32'h00000000, 32'h80000000, 4'b0011, 3'b100, 3'b000}, // R4 +0 == -0
    {32'hC0000000, 32'hBF800000, 4'b0011, 3'b001, 3'b000}, // R4 negatives
    {32'h7F800000, 32'h7F7FFFFF, 4'b0011, 3'b000, 3'b000}, // R4 +inf
    {32'hFF800000, 32'hBF800000, 4'b0011, 3'b001, 3'b000}, // R4 -inf
    {32'h7FC00000, 32'h3F800000, 4'b0011, 3'b111, 3'b000}, // R3 qnan quiet
    {32'h7FC00000, 32'h3F800000, 4'b1011, 3'b111, 3'b010}, // R6 qnan signaling
    {32'h7F800001, 32'h3F800000, 4'b0011, 3'b111, 3'b010}, // R6 snan quiet
    {32'h3F800000, 32'h40000000, 4'b0011, 3'b001, 3'b000}, // set up 001
    {32'h3F800000, 32'h7F800001, 4'b0001, 3'b111, 3'b110}, // R7 blocked
    {32'h7FC00000, 32'h7FC00000, 4'b1001, 3'b111, 3'b110}, // R7 blocked
    {32'h00000001, 32'h00000000, 4'b0011, 3'b000, 3'b001}, // R8 masked den
    {32'h00000001, 32'h00000000, 4'b0111, 3'b100, 3'b000}, // R9 daz
    {32'h80000001, 32'h00000001, 4'b0111, 3'b100, 3'b000}, // R9 signed zeros
    {32'h80000001, 32'h00000000, 4'b0010, 3'b001, 3'b101}, // R7 den blocked
    {32'h00000001, 32'h7FC00000, 4'b0000, 3'b111, 3'b000}, // R8 nan hides den
    {32'h00000001, 32'h00000002, 4'b0011, 3'b001, 3'b001}, // R8 den order
    {32'h80000000, 32'h00000000, 4'b1000, 3'b100, 3'b000}, // R6 no nan no inv
    {32'hFF800000, 32'hFFC00000, 4'b0011, 3'b111, 3'b000}, // R3 neg qnan
    {32'h7FC00000, 32'h7F800000, 4'b0000, 3'b111, 3'b000}, // R6 quiet unmasked
    {32'h40000000, 32'h3F800000, 4'b0011, 3'b000, 3'b000}, // set up 000
    {32'h7FBFFFFF, 32'h00000000, 4'b0001, 3'b111, 3'b110}  // R3 bit22 snan
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        sig_mode = 1'b0;
  logic        daz_en = 1'b0;
  logic        mask_inv = 1'b1;
  logic        mask_den = 1'b1;
  logic        sticky_clr = 1'b0;
  logic        out_done, out_exc;
  logic        flag_zf, flag_pf, flag_cf, flag_of, flag_sf, flag_af;
  logic        stat_inv, stat_den;

  int checks = 0;
  int failures = 0;
  logic [2:0] model_flags = 3'b000;
  logic       model_inv = 1'b0;
  logic       model_den = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_flag_unit i_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .sig_mode(sig_mode), .daz_en(daz_en),
    .mask_inv(mask_inv), .mask_den(mask_den), .sticky_clr(sticky_clr),
    .out_done(out_done), .out_exc(out_exc),
    .flag_zf(flag_zf), .flag_pf(flag_pf), .flag_cf(flag_cf),
    .flag_of(flag_of), .flag_sf(flag_sf), .flag_af(flag_af),
    .stat_inv(stat_inv), .stat_den(stat_den)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    opa = a; opb = b;
    {sig_mode, daz_en, mask_inv, mask_den} = m;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {7'd0, in_ready}, 8'd1);
    check("R1 done/exc", {6'd0, out_done, out_exc}, 8'd0);
    check("R1 flags", {5'd0, flag_zf, flag_pf, flag_cf}, 8'd0);
    check("R1 sticky", {6'd0, stat_inv, stat_den}, 8'd0);
    check("R5 zero flags", {5'd0, flag_of, flag_sf, flag_af}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] code;
      logic [2:0] ev;
      code = VECS[i][5:3];
      ev   = VECS[i][2:0];
      drive(VECS[i][73:42], VECS[i][41:10], VECS[i][9:6]);
      @(negedge clk);
      in_valid = 1'b0;
      if (!ev[2]) model_flags = code;
      model_inv = model_inv | ev[1];
      model_den = model_den | ev[0];
      check($sformatf("R11 done v%0d", i), {7'd0, out_done}, 8'd1);
      check($sformatf("R7 exc v%0d", i), {7'd0, out_exc}, {7'd0, ev[2]});
      check($sformatf("R2 flags v%0d", i), {5'd0, flag_zf, flag_pf, flag_cf}, {5'd0, model_flags});
      check($sformatf("R10 sticky v%0d", i), {6'd0, stat_inv, stat_den}, {6'd0, model_inv, model_den});
      check($sformatf("R5 v%0d", i), {5'd0, flag_of, flag_sf, flag_af}, 8'd0);
    end

    // R11: idle cycles produce no done and leave flags alone
    repeat (3) @(negedge clk);
    check("R11 idle done", {7'd0, out_done}, 8'd0);
    check("R11 idle flags", {5'd0, flag_zf, flag_pf, flag_cf}, {5'd0, model_flags});

    // R11: back-to-back pairs, one done each
    drive(32'h3F800000, 32'h40000000, 4'b0011);
    @(negedge clk);
    check("R11 b2b first done", {7'd0, out_done}, 8'd1);
    check("R11 b2b first flags", {5'd0, flag_zf, flag_pf, flag_cf}, 8'b001);
    drive(32'h40000000, 32'h40000000, 4'b0011);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 b2b second done", {7'd0, out_done}, 8'd1);
    check("R11 b2b second flags", {5'd0, flag_zf, flag_pf, flag_cf}, 8'b100);
    @(negedge clk);
    check("R11 b2b after", {7'd0, out_done}, 8'd0);

    // R10: sticky survives idle, clears on request
    check("R10 sticky held", {6'd0, stat_inv, stat_den}, 8'b11);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    check("R10 sticky cleared", {6'd0, stat_inv, stat_den}, 8'b00);

    // R10: set wins over clear in the same cycle
    sticky_clr = 1'b1;
    drive(32'h7F800001, 32'h00000000, 4'b0011);
    @(negedge clk);
    in_valid = 1'b0;
    sticky_clr = 1'b0;
    check("R10 set beats clear", {6'd0, stat_inv, stat_den}, 8'b10);
    check("R3 masked snan flags", {5'd0, flag_zf, flag_pf, flag_cf}, 8'b111);

    // R9: daz with mask_den=0 and a denormal gives no exception
    drive(32'h80000005, 32'h00000000, 4'b0110);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 daz no exc", {7'd0, out_exc}, 8'd0);
    check("R9 daz equal", {5'd0, flag_zf, flag_pf, flag_cf}, 8'b100);
    check("R9 daz no den sticky", {7'd0, stat_den}, 8'd0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule